// File: doc/BRIEF.md
# Multichannel Audio ADC Serial Capture Master

This block sits beside a multichannel audio converter whose serial port is a slave. It divides its own system clock down to a bit clock and a frame clock, drives both to the converter, and reads two serial data lanes. Each lane carries a left and a right channel, so every frame yields four 24-bit samples. The converter has no data-ready output. Sample boundaries are taken only from the frame-clock edges that this block produces.

The lanes are sampled on the rising bit-clock edge, because the converter moves its data on the falling edge. The frame clock is high for the left channel and low for the right channel. Framing is either left-justified or I2S, chosen by one input that is taken up only at a frame boundary. After reset, capture stays off until a holdoff of master-clock cycles has covered the converter's start-up. At the end of each captured frame, the four samples are updated together and a single-cycle valid strobe is raised.

Top module: `adcrx_master`

## Requirements
- R1: `bclk` is low after reset and has a period of BCLK_DIV master-clock cycles, with exactly BCLK_DIV/2 cycles high and BCLK_DIV/2 cycles low.
- R2: `fsync` is high after reset and toggles every 32 bit-clock periods. It changes only on the cycle in which `bclk` falls. High marks the left half of the frame and low marks the right half.
- R3: `smp_valid` never asserts before HOLDOFF master-clock cycles after reset. The first valid belongs to the first full frame that starts after the holdoff, and it carries the correct samples.
- R4: With `fmt_i2s`=0 (left-justified), the sample MSB sits in the first bit slot of each half. The 24 bits follow MSB first, one per rising `bclk` edge.
- R5: With `fmt_i2s`=1 (I2S), the first bit slot of each half is skipped. The MSB sits in the second slot and the 24 bits follow MSB first.
- R6: Bit slots outside the 24-bit data window of each half (8 in left-justified mode, 7 trailing plus 1 leading in I2S) have no effect on any sample output.
- R7: `smp_valid` is a one-cycle pulse, once per frame. It asserts after the right half's last data bit, while `fsync` is low. The sample outputs change only in a cycle where `smp_valid` is high.
- R8: `fmt_i2s` is taken up only at the frame boundary (the fall of `bclk` that ends bit slot 63). A change part-way through a frame leaves that frame framed in the old format, and the next frame uses the new one.
- R9: Lane `sdata_a` feeds `a_left`/`a_right` and lane `sdata_b` feeds `b_left`/`b_right`. The `fsync`-high half goes to the left outputs, and no lane leaks into another.
- R10: After reset, all four sample outputs are zero and `smp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all logic and both generated clocks derive from it |
| rst | input | 1 | Synchronous active-high reset |
| fmt_i2s | input | 1 | Framing select: 0 left-justified, 1 I2S |
| sdata_a | input | 1 | Serial data lane A (two channels) |
| sdata_b | input | 1 | Serial data lane B (two channels) |
| bclk | output | 1 | Generated bit clock |
| fsync | output | 1 | Generated frame clock, high for the left half |
| a_left | output | 24 | Lane A left sample |
| a_right | output | 24 | Lane A right sample |
| b_left | output | 24 | Lane B left sample |
| b_right | output | 24 | Lane B right sample |
| smp_valid | output | 1 | One-cycle strobe: the four samples are new |

## Verification
The bench runs a converter model that drives the lanes from the falling edge of the generated bit clock. This model fills the unused slots with ones, so a capture window that is off by one slot shows up as corrupted low or high sample bits. The model sends live data even during the holdoff, so a block that armed early would raise valid too soon. The format input is flipped in the middle of a frame, and a block that took it up at once would misframe that frame by one bit. Each lane and half gets a distinct pattern, so swapped lanes or halves give mismatches rather than equal values by chance.

// File: rtl/adcrx_pkg.sv
package adcrx_pkg;

    localparam int SMP_W   = 24;
    localparam int SLOT_W  = 32;
    localparam int FRAME_W = 2 * SLOT_W;
    localparam int IDX_W   = $clog2(FRAME_W);
    localparam int POS_W   = $clog2(SLOT_W);

    typedef enum logic {
        FMT_LJ  = 1'b0,
        FMT_I2S = 1'b1
    } fmt_e;

    typedef struct packed {
        logic [SMP_W-1:0] left;
        logic [SMP_W-1:0] right;
    } lane_smp_t;

    // slot of the MSB within a half
    function automatic logic [POS_W-1:0] first_pos(fmt_e f);
        return (f == FMT_I2S) ? POS_W'(1) : POS_W'(0);
    endfunction

    // slot of the LSB within a half
    function automatic logic [POS_W-1:0] last_pos(fmt_e f);
        return first_pos(f) + POS_W'(SMP_W - 1);
    endfunction

    function automatic logic in_window(logic [POS_W-1:0] pos, fmt_e f);
        return (pos >= first_pos(f)) && (pos <= last_pos(f));
    endfunction

endpackage

// File: rtl/adcrx_clkgen.sv
module adcrx_clkgen
    import adcrx_pkg::*;
#(
    parameter int BCLK_DIV = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic             bclk,
    output logic             fsync,
    output logic [IDX_W-1:0] bit_idx,
    output logic             rise_stb,
    output logic             frame_end
);

    localparam int CW   = (BCLK_DIV > 2) ? $clog2(BCLK_DIV) : 1;
    localparam int HALF = BCLK_DIV / 2;

    logic [CW-1:0]    div_q;
    logic             fall_stb;
    logic [IDX_W-1:0] idx_nxt;

    assign rise_stb  = (div_q == CW'(HALF - 1));
    assign fall_stb  = (div_q == CW'(BCLK_DIV - 1));
    assign idx_nxt   = bit_idx + IDX_W'(1);
    assign frame_end = fall_stb && (bit_idx == IDX_W'(FRAME_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (fall_stb) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk    <= 1'b0;
            fsync   <= 1'b1;
            bit_idx <= '0;
        end else begin
            if (rise_stb) begin
                bclk <= 1'b1;
            end
            if (fall_stb) begin
                bclk    <= 1'b0;
                bit_idx <= idx_nxt;
                fsync   <= ~idx_nxt[IDX_W-1];
            end
        end
    end

endmodule

// File: rtl/adcrx_lane.sv
module adcrx_lane
    import adcrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sdata,
    input  logic      cap,
    input  logic      right_half,
    output lane_smp_t smp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            smp <= '0;
        end else if (cap) begin
            if (right_half) begin
                smp.right <= {smp.right[SMP_W-2:0], sdata};
            end else begin
                smp.left  <= {smp.left[SMP_W-2:0], sdata};
            end
        end
    end

endmodule

// File: rtl/adcrx_master.sv
module adcrx_master
    import adcrx_pkg::*;
#(
    parameter int BCLK_DIV = 4,
    parameter int HOLDOFF  = 1024
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fmt_i2s,
    input  logic             sdata_a,
    input  logic             sdata_b,
    output logic             bclk,
    output logic             fsync,
    output logic [SMP_W-1:0] a_left,
    output logic [SMP_W-1:0] a_right,
    output logic [SMP_W-1:0] b_left,
    output logic [SMP_W-1:0] b_right,
    output logic             smp_valid
);

    localparam int LANES = 2;
    localparam int HW    = $clog2(HOLDOFF + 1);

    logic [IDX_W-1:0] bit_idx;
    logic             rise_stb;
    logic             frame_end;

    adcrx_clkgen #(.BCLK_DIV(BCLK_DIV)) u_clkgen (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .fsync     (fsync),
        .bit_idx   (bit_idx),
        .rise_stb  (rise_stb),
        .frame_end (frame_end)
    );

    // start-up holdoff
    logic [HW-1:0] hold_cnt;
    logic          hold_done;

    assign hold_done = (hold_cnt == HW'(HOLDOFF));

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (!hold_done) begin
            hold_cnt <= hold_cnt + HW'(1);
        end
    end

    // per-frame control, latched at the boundary
    fmt_e mode_q;
    logic armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= FMT_LJ;
            armed_q <= 1'b0;
        end else if (frame_end) begin
            mode_q  <= fmt_e'(fmt_i2s);
            armed_q <= hold_done;
        end
    end

    logic [POS_W-1:0] pos;
    logic             right_half;
    logic             cap;
    logic             last_bit;

    assign pos        = bit_idx[POS_W-1:0];
    assign right_half = bit_idx[IDX_W-1];
    assign cap        = rise_stb && armed_q && in_window(pos, mode_q);
    assign last_bit   = cap && right_half && (pos == last_pos(mode_q));

    // lane shifters
    logic [LANES-1:0] sd;
    lane_smp_t        lane_q [LANES];
    lane_smp_t        out_q  [LANES];

    assign sd = {sdata_b, sdata_a};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        adcrx_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .sdata      (sd[g]),
            .cap        (cap),
            .right_half (right_half),
            .smp        (lane_q[g])
        );
    end

    // output bank
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            smp_valid <= 1'b0;
            for (int i = 0; i < LANES; i++) begin
                out_q[i] <= '0;
            end
        end else begin
            pend_q    <= last_bit;
            smp_valid <= pend_q;
            if (pend_q) begin
                for (int i = 0; i < LANES; i++) begin
                    out_q[i] <= lane_q[i];
                end
            end
        end
    end

    assign a_left  = out_q[0].left;
    assign a_right = out_q[0].right;
    assign b_left  = out_q[1].left;
    assign b_right = out_q[1].right;

endmodule

// File: rtl/adcrx_master_chk.sv
module adcrx_master_chk
    import adcrx_pkg::*;
#(
    parameter int BCLK_DIV = 4,
    parameter int HOLDOFF  = 1024
) (
    input logic             clk,
    input logic             rst,
    input logic             bclk,
    input logic             fsync,
    input logic             smp_valid,
    input logic [SMP_W-1:0] a_left,
    input logic [SMP_W-1:0] a_right,
    input logic [SMP_W-1:0] b_left,
    input logic [SMP_W-1:0] b_right
);

    localparam int RW = $clog2(BCLK_DIV + 2);
    localparam int HW = $clog2(HOLDOFF + 1);

    logic          bclk_d;
    logic          fsync_d;
    logic [RW-1:0] run_q;
    logic [HW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_d    <= 1'b0;
            fsync_d   <= 1'b1;
            run_q     <= '0;
            since_rst <= '0;
        end else begin
            bclk_d  <= bclk;
            fsync_d <= fsync;
            if (bclk != bclk_d) begin
                run_q <= RW'(1);
            end else if (run_q != {RW{1'b1}}) begin
                run_q <= run_q + RW'(1);
            end
            if (since_rst != HW'(HOLDOFF)) begin
                since_rst <= since_rst + HW'(1);
            end
        end
    end

    // R1: every bit-clock level lasts half the divide ratio
    p_bclk_duty_r1: assert property (@(posedge clk) disable iff (rst)
        (bclk != bclk_d) |-> (run_q == RW'(BCLK_DIV / 2)));

    // R2: frame clock moves only with a falling bit clock
    p_fsync_edge_r2: assert property (@(posedge clk) disable iff (rst)
        (fsync != fsync_d) |-> (!bclk && bclk_d));

    // R3: nothing is reported during the start-up holdoff
    p_holdoff_r3: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> (since_rst == HW'(HOLDOFF)));

    // R7: valid lands in the right half
    p_valid_right_r7: assert property (@(posedge clk) disable iff (rst)
        smp_valid |-> !fsync);

    // R7: valid is a single-cycle pulse
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> !smp_valid);

    // R7: sample outputs move only together with valid
    p_out_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |-> ($stable(a_left) && $stable(a_right) &&
                        $stable(b_left) && $stable(b_right)));

endmodule

bind adcrx_master adcrx_master_chk #(
    .BCLK_DIV (BCLK_DIV),
    .HOLDOFF  (HOLDOFF)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bclk      (bclk),
    .fsync     (fsync),
    .smp_valid (smp_valid),
    .a_left    (a_left),
    .a_right   (a_right),
    .b_left    (b_left),
    .b_right   (b_right)
);

// File: tb/adcrx_master_bench.sv
`timescale 1ns/1ps
module adcrx_master_bench;

    localparam int DIV  = 4;
    localparam int HOLD = 1024;
    localparam int FRM  = 64 * DIV;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_i2s = 1'b0;
    logic        sdata_a = 1'b0;
    logic        sdata_b = 1'b0;
    logic        bclk, fsync, smp_valid;
    logic [23:0] a_left, a_right, b_left, b_right;

    int checks = 0;
    int errors = 0;

    // converter model state
    logic [23:0] v_al, v_ar, v_bl, v_br;
    logic        fill = 1'b1;
    logic        cmode = 1'b0;

    always #4 clk = ~clk;

    adcrx_master #(.BCLK_DIV(DIV), .HOLDOFF(HOLD)) u_adcrx_master (
        .clk       (clk),
        .rst       (rst),
        .fmt_i2s   (fmt_i2s),
        .sdata_a   (sdata_a),
        .sdata_b   (sdata_b),
        .bclk      (bclk),
        .fsync     (fsync),
        .a_left    (a_left),
        .a_right   (a_right),
        .b_left    (b_left),
        .b_right   (b_right),
        .smp_valid (smp_valid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic lane_bit(logic [23:0] w, int pos, logic i2s, logic pad);
        int k = pos - (i2s ? 1 : 0);
        if (k >= 0 && k < 24) return w[23 - k];
        return pad;
    endfunction

    // serial slave: shifts on the falling bit clock
    task automatic converter();
        logic prv = 1'b1;
        int   pos = 0;
        forever begin
            @(negedge bclk);
            #1;
            if (fsync != prv) begin
                pos = 0;
                prv = fsync;
                if (fsync) cmode = fmt_i2s;
            end else begin
                pos++;
            end
            sdata_a = lane_bit(fsync ? v_al : v_ar, pos, cmode, fill);
            sdata_b = lane_bit(fsync ? v_bl : v_br, pos, cmode, fill);
        end
    endtask

    task automatic wait_valid();
        do @(negedge clk); while (!smp_valid);
    endtask

    task automatic set_vals(logic [23:0] al, ar, bl, br);
        v_al = al; v_ar = ar; v_bl = bl; v_br = br;
    endtask

    task automatic cmp_out(string req);
        check({req, " a_left"},  {8'h0, a_left},  {8'h0, v_al});
        check({req, " a_right"}, {8'h0, a_right}, {8'h0, v_ar});
        check({req, " b_left"},  {8'h0, b_left},  {8'h0, v_bl});
        check({req, " b_right"}, {8'h0, b_right}, {8'h0, v_br});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 valid", {31'h0, smp_valid}, 32'h0);
        check("R10 a_left", {8'h0, a_left}, 32'h0);
        check("R10 b_right", {8'h0, b_right}, 32'h0);
        check("R1 bclk low", {31'h0, bclk}, 32'h0);
        check("R2 fsync high", {31'h0, fsync}, 32'h1);
    endtask

    task automatic t_holdoff();
        int n = 0;
        set_vals(24'hA5C3F1, 24'h5A3C1F, 24'h123456, 24'hFEDCBA);
        rst = 1'b0;
        fork converter(); join_none
        do begin @(negedge clk); n++; end while (!smp_valid);
        check("R3 no valid in holdoff", {31'h0, (n >= HOLD)}, 32'h1);
        check("R3 first frame after holdoff", {31'h0, (n <= HOLD + 2 * FRM)}, 32'h1);
        cmp_out("R3 first samples");
    endtask

    task automatic t_clocks();
        int hi = 0, lo = 0, rises = 0;
        logic f0;
        @(negedge clk);
        while (bclk) @(negedge clk);
        while (!bclk) @(negedge clk);
        while (bclk) begin hi++; @(negedge clk); end
        while (!bclk) begin lo++; @(negedge clk); end
        check("R1 high time", hi, DIV / 2);
        check("R1 low time", lo, DIV / 2);
        f0 = fsync;
        while (fsync == f0) @(negedge clk);
        f0 = fsync;
        while (fsync == f0) begin
            @(negedge clk);
            if (bclk && rises >= 0) begin
                rises++;
                while (bclk) @(negedge clk);
            end
        end
        check("R2 bits per half", rises, 32);
    endtask

    task automatic t_frame(string req, logic i2s, logic pad,
                           logic [23:0] al, ar, bl, br);
        wait_valid();
        fmt_i2s = i2s;
        fill = pad;
        set_vals(al, ar, bl, br);
        wait_valid();
        wait_valid();
        cmp_out(req);
    endtask

    task automatic t_rate();
        int cnt = 0, wid = 0;
        wait_valid();
        for (int i = 0; i < 8 * FRM; i++) begin
            @(negedge clk);
            if (smp_valid) begin
                cnt++;
                @(negedge clk);
                i++;
                if (smp_valid) wid++;
            end
        end
        check("R7 one valid per frame", cnt, 8);
        check("R7 single-cycle valid", wid, 0);
    endtask

    task automatic t_midswitch();
        fmt_i2s = 1'b0;
        wait_valid();
        wait_valid();
        set_vals(24'h8000FF, 24'h00FF01, 24'hC0FFEE, 24'h7F0080);
        repeat (100) @(negedge clk);
        fmt_i2s = 1'b1;
        wait_valid();
        cmp_out("R8 frame keeps old format");
        set_vals(24'h96A569, 24'h0F0F0F, 24'hF0F0F0, 24'h333CCC);
        wait_valid();
        cmp_out("R8 next frame new format");
    endtask

    initial begin
        v_al = '0; v_ar = '0; v_bl = '0; v_br = '0;
        repeat (4) @(negedge clk);
        t_reset();
        t_holdoff();
        t_clocks();
        t_frame("R4 R9 lj", 1'b0, 1'b0, 24'h800001, 24'h7FFFFE, 24'hF00F0F, 24'h0AA550);
        t_frame("R4 R6 lj ones pad", 1'b0, 1'b1, 24'h000000, 24'h000001, 24'h800000, 24'h3C3C3C);
        t_frame("R5 R9 i2s", 1'b1, 1'b0, 24'hFFFFFF, 24'h000000, 24'h13579B, 24'hECA864);
        t_frame("R5 R6 i2s ones pad", 1'b1, 1'b1, 24'h000000, 24'h400002, 24'h000001, 24'h800000);
        t_rate();
        t_midswitch();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule